// File: doc/BRIEF.md
# Dual-Clock Byte-to-Word Packet Buffer

This block is a packet store between a byte-wide network datapath and a 32-bit bus. It is organised as `2^BUF_W` packet slots of `2^OFF_W` bytes each. A producer on the network clock writes one byte per clock. It picks the slot with a slot index and the position with a byte offset. A consumer on a slower, unrelated bus clock reads 32-bit words, addressed by a slot index and a word offset within the slot.

Four bytes with consecutive offsets pack into one word, lowest offset in the least significant byte. The store is inferred from plain arrays: four byte-wide banks, one per byte lane. Each bank has a write port on the network clock and a registered read port on the bus clock.

The block does not track which slots are full or free, and it does not interpret packet contents. The surrounding logic must not read a location in the same window in which it is being written.

Top module: `pbuf_async_ram`

## Requirements
- R1: On a rising edge of `wr_clk` with `wr_en` high, the byte `wr_byte` is stored at byte offset `wr_off` of slot `wr_slot`, and exactly one byte lane is written.
- R2: On a rising edge of `wr_clk` with `wr_en` low, no stored byte changes, whatever the other write inputs carry.
- R3: The byte at offset `4*k+i` of a slot is returned in bits `[8*i+7:8*i]` of word `k` of that slot (i = 0..3). Writing one byte leaves the other three lanes of its word unchanged.
- R4: `rd_data` takes the word addressed by `rd_slot`/`rd_word` as sampled on a rising edge of `rd_clk`, and changes only at such an edge. An address change between edges has no effect until the next edge.
- R5: Slots are independent. Writes to one slot leave the contents of every other slot unchanged.
- R6: While `rd_rst_n` is low, `rd_data` is zero. The stored contents are not affected by this reset and read back intact after it is released.
- R7: Writes on `wr_clk` and reads on the unrelated, slower `rd_clk` may run at the same time on different slots without disturbing each other.
- R8: The full address range is usable, including the last byte offset of the highest slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Network-side clock |
| wr_en | input | 1 | Byte write enable |
| wr_slot | input | BUF_W | Slot index for the write |
| wr_off | input | OFF_W | Byte offset within the slot |
| wr_byte | input | 8 | Byte to store |
| rd_clk | input | 1 | Bus-side clock, slower and unrelated |
| rd_rst_n | input | 1 | Active-low asynchronous reset of the read register, released synchronously by the caller |
| rd_slot | input | BUF_W | Slot index for the read |
| rd_word | input | OFF_W-2 | Word offset within the slot |
| rd_data | output | 32 | Registered read word |

## Verification
The embedded assertions check three things on every write clock: an idle write selects no lane, an active write selects exactly one lane, and the written byte lands in its bank at the addressed row. On the read clock they check that the read register leaves reset at zero.

The byte packing order, slot isolation, the one-edge read latency, retention of contents across a read-side reset, and the independence of concurrent writes and reads only show up in the bench scenarios. There, a behavioural byte-array model predicts every word read back.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int unsigned LANES     = 4;
  localparam int unsigned LANE_BITS = 2;
  localparam int unsigned BYTE_W    = 8;

  typedef logic [LANES-1:0] lane_mask_t;

  // one-hot lane select from the low bits of a byte offset
  function automatic lane_mask_t lane_select(input logic [LANE_BITS-1:0] sel);
    lane_mask_t m;
    m = '0;
    m[sel] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pbuf_lane_dec.sv
module pbuf_lane_dec
  import pbuf_pkg::*;
(
  input  logic                 wr_clk,
  input  logic                 wr_en,
  input  logic [LANE_BITS-1:0] lane_sel,
  output lane_mask_t           lane_we
);

  always_comb begin
    lane_we = '0;
    if (wr_en) begin
      lane_we = lane_select(lane_sel);
    end
  end

  // R2: an idle write cycle touches no bank
  a_r2_idle_no_lane: assert property (@(posedge wr_clk) !wr_en |-> lane_we == '0);

  // R1: an active write cycle touches exactly one bank
  a_r1_single_lane: assert property (@(posedge wr_clk) wr_en |-> $countones(lane_we) == 1);

endmodule

// File: rtl/pbuf_bank.sv
module pbuf_bank
  import pbuf_pkg::*;
#(
  parameter int unsigned ROW_W = 9,
  localparam int unsigned ROWS = 1 << ROW_W
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [BYTE_W-1:0] rd_q
);

  logic [BYTE_W-1:0] mem [ROWS];
  logic [BYTE_W-1:0] rd_q_nxt;

  // write port, no reset on contents
  always_ff @(posedge wr_clk) begin
    if (we) begin
      mem[wr_row] <= wr_byte;
    end
  end

  always_comb begin
    rd_q_nxt = mem[rd_row];
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_q_nxt;
    end
  end

  // R1: the written byte is present in the addressed row after the edge
  a_r1_write_lands: assert property (@(posedge wr_clk) we |=> mem[$past(wr_row)] == $past(wr_byte));

  // R6: the read register comes out of reset holding zero
  a_r6_reset_clear: assert property (@(posedge rd_clk) $rose(rd_rst_n) |-> rd_q == '0);

endmodule

// File: rtl/pbuf_async_ram.sv
module pbuf_async_ram
  import pbuf_pkg::*;
#(
  parameter int unsigned BUF_W = 4,
  parameter int unsigned OFF_W = 7,
  localparam int unsigned WORD_W = OFF_W - LANE_BITS,
  localparam int unsigned ROW_W  = BUF_W + WORD_W
) (
  input  logic                     wr_clk,
  input  logic                     wr_en,
  input  logic [BUF_W-1:0]         wr_slot,
  input  logic [OFF_W-1:0]         wr_off,
  input  logic [BYTE_W-1:0]        wr_byte,
  input  logic                     rd_clk,
  input  logic                     rd_rst_n,
  input  logic [BUF_W-1:0]         rd_slot,
  input  logic [WORD_W-1:0]        rd_word,
  output logic [LANES*BYTE_W-1:0]  rd_data
);

  logic [ROW_W-1:0] wr_row;
  logic [ROW_W-1:0] rd_row;
  lane_mask_t       lane_we;

  always_comb begin
    wr_row = {wr_slot, wr_off[OFF_W-1:LANE_BITS]};
    rd_row = {rd_slot, rd_word};
  end

  pbuf_lane_dec u_dec (
    .wr_clk   (wr_clk),
    .wr_en    (wr_en),
    .lane_sel (wr_off[LANE_BITS-1:0]),
    .lane_we  (lane_we)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pbuf_bank #(.ROW_W(ROW_W)) u_bank (
      .wr_clk   (wr_clk),
      .we       (lane_we[g]),
      .wr_row   (wr_row),
      .wr_byte  (wr_byte),
      .rd_clk   (rd_clk),
      .rd_rst_n (rd_rst_n),
      .rd_row   (rd_row),
      .rd_q     (rd_data[g*BYTE_W +: BYTE_W])
    );
  end

endmodule

// File: tb/tb_pbuf_async_ram.sv
module tb_pbuf_async_ram;
  localparam int BUF_W = 4;
  localparam int OFF_W = 7;
  localparam int WORD_W = OFF_W - 2;
  localparam int SLOT_BYTES = 1 << OFF_W;
  localparam int SLOT_WORDS = 1 << WORD_W;

  logic              wr_clk = 1'b0;
  logic              rd_clk = 1'b0;
  logic              wr_en;
  logic [BUF_W-1:0]  wr_slot;
  logic [OFF_W-1:0]  wr_off;
  logic [7:0]        wr_byte;
  logic              rd_rst_n;
  logic [BUF_W-1:0]  rd_slot;
  logic [WORD_W-1:0] rd_word;
  logic [31:0]       rd_data;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [7:0] model [int];

  always #2.5 wr_clk = ~wr_clk;
  always #6.85 rd_clk = ~rd_clk;

  pbuf_async_ram #(.BUF_W(BUF_W), .OFF_W(OFF_W)) dut (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_off(wr_off), .wr_byte(wr_byte),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(rd_data)
  );

  function automatic logic [31:0] exp_word(int s, int w);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) v[8*i +: 8] = model[s*SLOT_BYTES + 4*w + i];
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr_one(int s, int o, logic [7:0] b, bit en);
    @(negedge wr_clk);
    wr_en = en; wr_slot = BUF_W'(s); wr_off = OFF_W'(o); wr_byte = b;
    @(posedge wr_clk);
    if (en) model[s*SLOT_BYTES + o] = b;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic fill_slot(int s);
    for (int o = 0; o < SLOT_BYTES; o++) wr_one(s, o, 8'($urandom), 1'b1);
  endtask

  task automatic rd_chk(int s, int w, string tag);
    @(negedge rd_clk);
    rd_slot = BUF_W'(s); rd_word = WORD_W'(w);
    @(negedge rd_clk);
    check(tag, rd_data, exp_word(s, w));
  endtask

  task automatic rd_slot_all(int s, string tag);
    for (int w = 0; w < SLOT_WORDS; w++) rd_chk(s, w, tag);
  endtask

  initial begin
    wr_en = 1'b0; wr_slot = '0; wr_off = '0; wr_byte = '0;
    rd_slot = '0; rd_word = '0;
    rd_rst_n = 1'b0;
    repeat (3) @(negedge rd_clk);
    check("R6 reset value", rd_data, 32'h0);
    rd_rst_n = 1'b1;

    // R1 R3 R8: fill slots including the highest, read every word
    fill_slot(0); fill_slot(3); fill_slot(15);
    rd_slot_all(0, "R1 slot0");
    rd_slot_all(3, "R3 slot3");
    rd_slot_all(15, "R8 slot15");

    // R2: disabled writes must not change slot 3
    for (int o = 0; o < 16; o++) wr_one(3, o, 8'hA5 ^ 8'(o), 1'b0);
    for (int w = 0; w < 4; w++) rd_chk(3, w, "R2 disabled write");

    // R3: single lane overwrite of word 5, lane 2 in bits 23:16
    wr_one(0, 4*5 + 2, 8'h3C, 1'b1);
    rd_chk(0, 5, "R3 single lane");
    check("R3 lane position", {8'h0, rd_data[23:16], 16'h0}, {8'h0, 8'h3C, 16'h0});

    // R5: writes to slot 3 left slots 0 and 15 intact
    wr_one(3, 0, 8'h11, 1'b1);
    rd_chk(15, 0, "R5 isolation");
    rd_chk(0, 0, "R5 isolation");

    // R4: address change between edges has no effect until next edge
    rd_chk(3, 7, "R4 first");
    @(negedge rd_clk);
    rd_slot = 4'd15; rd_word = 5'd9;
    #1;
    check("R4 hold before edge", rd_data, exp_word(3, 7));
    @(negedge rd_clk);
    check("R4 after edge", rd_data, exp_word(15, 9));

    // R6: reset clears the output only; contents survive
    @(negedge rd_clk);
    rd_rst_n = 1'b0;
    #1;
    check("R6 async clear", rd_data, 32'h0);
    @(negedge rd_clk);
    check("R6 held in reset", rd_data, 32'h0);
    rd_rst_n = 1'b1;
    rd_chk(15, 9, "R6 contents kept");
    rd_chk(0, 5, "R6 contents kept");

    // R7: concurrent write on one slot and read on another
    fork
      fill_slot(7);
      rd_slot_all(0, "R7 concurrent read");
    join
    rd_slot_all(7, "R7 written slot");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge wr_clk);
        errors++;
        vectors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule